// File: doc/BRIEF.md
# Gatable Free-Running / One-Shot Pulse Generator

This block produces a digital pulse train or a single timed pulse from a programmable cycle counter. The counter replaces the resistor-capacitor network of a classic analog multivibrator. It has two operating modes.

**Free-running mode.** The block runs as a gatable square-wave oscillator while either of its two run-enable inputs is active. One input is active high and the other is active low. Two outputs are produced:
- a fast oscillator tap;
- a main output at half the tap's rate, with its complement.

**One-shot mode.** When both enables are inactive, the block acts as an edge-triggered one-shot. A pulse starts in either of two ways:
- a rising edge on the up-trigger while the down-trigger is low;
- a falling edge on the down-trigger while the up-trigger is high.

A separate re-arm input also starts a pulse on its rising edge. While re-arm stays high it keeps restarting the timing, so the pulse is stretched for as long as re-arm is held.

**Forced clear.** An asynchronous-looking forced clear blanks the outputs in the same cycle, abandons any pulse or oscillation, and blocks new pulses while it is held. Trigger and re-arm inputs pass through a two-flop synchroniser before edge detection. The run enables and the forced clear are taken as synchronous inputs.

Top module: `mvgen_top`

## Requirements
- R1: When `run_hi` is 1 or `run_lo_n` is 0 (and `force_clr` is 0), the first rising clock edge that sees the enable puts the block in free-running mode with `pulse_out`=1 and `osc_tap`=1.
- R2: In free-running mode, with L = `period_len` (a value of 0 counts as 1), `osc_tap` toggles every L cycles. `pulse_out` toggles on every 0→1 step of `osc_tap`, so `pulse_out` is high for 2L cycles and low for 2L cycles. L is re-sampled at each tap toggle.
- R3: When neither enable is active, `pulse_out` and `osc_tap` are 0 from the next rising edge on, and neither output toggles. The exception is `pulse_out` during a one-shot pulse.
- R4: A rising edge on `trig_up` while `trig_dn` is low starts a pulse. `pulse_out` rises at the third rising clock edge after the input changes. It stays high for exactly L cycles, where L is `period_len` sampled at the trigger (0 counts as 1). Later changes to `period_len` do not alter that pulse.
- R5: A falling edge on `trig_dn` while `trig_up` is high starts a pulse with the same latency and length as R4.
- R6: A trigger edge that arrives while a pulse is active, with `rearm` low, is ignored: the pulse ends L cycles after its own start.
- R7: A rising edge on `rearm` starts a pulse with the R4 latency. While `rearm` stays high the timing restarts every cycle. `pulse_out` falls at the (L+2)-th rising edge after `rearm` is lowered.
- R8: While `force_clr` is 1, `pulse_out`=0, `pulse_out_n`=1 and `osc_tap`=0 in the same cycle. Any pulse or oscillation is abandoned, and no trigger seen during the clear produces a pulse, during or after it.
- R9: A rising clock edge with `rst_n`=0 sets `pulse_out`=0, `pulse_out_n`=1 and `osc_tap`=0.
- R10: `pulse_out_n` is always the exact complement of `pulse_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_hi | input | 1 | Free-running enable, active high |
| run_lo_n | input | 1 | Free-running enable, active low |
| trig_up | input | 1 | One-shot trigger on rising edge (when `trig_dn` is low) |
| trig_dn | input | 1 | One-shot trigger on falling edge (when `trig_up` is high) |
| rearm | input | 1 | Re-arm: rising edge starts a pulse, high level restarts timing |
| force_clr | input | 1 | Forced clear, active high |
| period_len | input | CNT_W | Timing length L in clock cycles (0 treated as 1) |
| pulse_out | output | 1 | Main output |
| pulse_out_n | output | 1 | Complement of the main output |
| osc_tap | output | 1 | Oscillator tap, twice the main output rate in free-running mode |

## Verification
The assertions check the following on every cycle:
- the counter stays inside its loaded length;
- a forced clear empties the state at the next edge;
- a disabled oscillator leaves the tap low;
- an enable always lands the block in free-running mode;
- the main output changes in free-running mode only on a rising tap;
- an active one-shot holds its output while no restart, clear or terminal count occurs.

The bench scenarios are what show the exact latencies, pulse lengths and waveform shapes:
- trigger-to-output latency, and pulse lengths including the zero-length case;
- the square-wave shape for both enable polarities;
- the stretch after re-arm is released;
- that triggers are ignored during a pulse or a clear, observed at the outputs.

// File: rtl/mvgen_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the pulse generator.
// Assumes: nothing beyond SystemVerilog 2017.
package mvgen_pkg;

    // Operating state of the controller
    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_MONO = 2'd1,
        MV_ASTB = 2'd2
    } mv_mode_e;

    // Decoded start/restart events for one clock cycle
    typedef struct packed {
        logic fire;      // trigger edge that may start a one-shot
        logic rt_rise;   // rising edge of re-arm
        logic rt_level;  // synchronised re-arm level
    } mv_evt_t;

endpackage

// File: rtl/mvgen_sync.sv
`timescale 1ns/1ps
// Module: multi-bit synchroniser chain with one extra stage for edge detection.
// cur is the synchronised level; prev is the same level one cycle older.
// Assumes: STAGES >= 1, each bit is an independent level signal.
module mvgen_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][W-1:0] stg;

    // Shift the input through the synchroniser and history stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign cur  = stg[STAGES-1];
    assign prev = stg[STAGES];

endmodule

// File: rtl/mvgen_trigdec.sv
`timescale 1ns/1ps
// Module: trigger decoder. Turns synchronised levels and their one-cycle
// history into start events: up rising while down low, down falling while
// up high, and re-arm rising plus re-arm level.
// Assumes: inputs come from mvgen_sync, so they are glitch-free.
module mvgen_trigdec
    import mvgen_pkg::*;
(
    input  logic    up_cur,
    input  logic    up_prev,
    input  logic    dn_cur,
    input  logic    dn_prev,
    input  logic    rt_cur,
    input  logic    rt_prev,
    output mv_evt_t evt
);
    logic up_rise;
    logic dn_fall;

    // Edge terms from current and previous synchronised levels
    always_comb begin
        up_rise = up_cur & ~up_prev;
        dn_fall = ~dn_cur & dn_prev;
    end

    // Qualify each trigger edge by the level of the other input
    always_comb begin
        evt.fire     = (up_rise & ~dn_cur) | (dn_fall & up_cur);
        evt.rt_rise  = rt_cur & ~rt_prev;
        evt.rt_level = rt_cur;
    end

endmodule

// File: rtl/mvgen_timebase.sv
`timescale 1ns/1ps
// Module: programmable timebase. restart clears the count and samples the
// length (0 treated as 1); advance counts; tick marks the last cycle of a
// length and reloads the length for the next interval.
// Assumes: the controller never raises restart and advance together.
module mvgen_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [CNT_W-1:0] len_in,
    output logic             tick
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] len_eff;
    logic             at_end;

    // Saturate a zero length up to one cycle
    always_comb begin
        len_eff = (len_in == '0) ? ONE : len_in;
        at_end  = (cnt == lim - ONE);
        tick    = advance & ~restart & at_end;
    end

    // Count within the sampled length, reloading it at restart and at each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            lim <= ONE;
        end else if (restart) begin
            cnt <= '0;
            lim <= len_eff;
        end else if (advance) begin
            if (at_end) begin
                cnt <= '0;
                lim <= len_eff;
            end else begin
                cnt <= cnt + ONE;
            end
        end else begin
            cnt <= '0;
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < lim);

    // R4
    lim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim != '0);

endmodule

// File: rtl/mvgen_ctrl.sv
`timescale 1ns/1ps
// Module: mode controller. Chooses between idle, one-shot and free-running
// operation, drives the timebase, and holds the main and tap output states.
// Assumes: run_en and ext_clr are synchronous; evt is already synchronised.
module mvgen_ctrl
    import mvgen_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run_en,
    input  logic    ext_clr,
    input  mv_evt_t evt,
    input  logic    tick,
    output logic    restart,
    output logic    advance,
    output logic    q_r,
    output logic    tap_r
);
    mv_mode_e mode_q;
    mv_mode_e mode_d;
    logic     q_d;
    logic     tap_d;

    // Timebase commands; independent of tick to keep the loop open
    always_comb begin
        restart = 1'b0;
        advance = 1'b0;
        if (!ext_clr) begin
            if (run_en) begin
                if (mode_q != MV_ASTB) restart = 1'b1;
                else                   advance = 1'b1;
            end else if (mode_q == MV_IDLE) begin
                restart = evt.fire | evt.rt_rise;
            end else if (mode_q == MV_MONO) begin
                if (evt.rt_level) restart = 1'b1;
                else              advance = 1'b1;
            end
        end
    end

    // Next mode and output states
    always_comb begin
        mode_d = mode_q;
        q_d    = q_r;
        tap_d  = tap_r;
        if (ext_clr) begin
            mode_d = MV_IDLE;
            q_d    = 1'b0;
            tap_d  = 1'b0;
        end else if (run_en) begin
            if (mode_q != MV_ASTB) begin
                mode_d = MV_ASTB;
                q_d    = 1'b1;
                tap_d  = 1'b1;
            end else if (tick) begin
                tap_d = ~tap_r;
                if (!tap_r) q_d = ~q_r;
            end
        end else begin
            case (mode_q)
                MV_ASTB: begin
                    mode_d = MV_IDLE;
                    q_d    = 1'b0;
                    tap_d  = 1'b0;
                end
                MV_IDLE: begin
                    if (evt.fire | evt.rt_rise) begin
                        mode_d = MV_MONO;
                        q_d    = 1'b1;
                        tap_d  = 1'b0;
                    end
                end
                MV_MONO: begin
                    if (tick) begin
                        mode_d = MV_IDLE;
                        q_d    = 1'b0;
                    end
                end
                default: begin
                    mode_d = MV_IDLE;
                    q_d    = 1'b0;
                    tap_d  = 1'b0;
                end
            endcase
        end
    end

    // State register with synchronous reset to idle and low outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MV_IDLE;
            q_r    <= 1'b0;
            tap_r  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            q_r    <= q_d;
            tap_r  <= tap_d;
        end
    end

    // R8
    clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clr |=> (!q_r && !tap_r && mode_q == MV_IDLE));

    // R3
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !tap_r);

    // R1
    astb_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !ext_clr) |=> (mode_q == MV_ASTB));

    // R2
    q_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MV_ASTB && $past(mode_q) == MV_ASTB && !$stable(q_r)) |-> $rose(tap_r));

    // R6
    mono_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MV_MONO && !evt.rt_level && !run_en && !ext_clr && !tick)
        |=> (mode_q == MV_MONO && q_r));

endmodule

// File: rtl/mvgen_top.sv
`timescale 1ns/1ps
// Module: gatable free-running / one-shot pulse generator top.
// Synchronises the trigger inputs, decodes start events, runs the shared
// timebase and controller, and blanks the outputs during a forced clear.
// Assumes: run_hi, run_lo_n, force_clr and period_len are synchronous to clk.
module mvgen_top #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_hi,
    input  logic             run_lo_n,
    input  logic             trig_up,
    input  logic             trig_dn,
    input  logic             rearm,
    input  logic             force_clr,
    input  logic [CNT_W-1:0] period_len,
    output logic             pulse_out,
    output logic             pulse_out_n,
    output logic             osc_tap
);
    import mvgen_pkg::*;

    localparam int NSYNC = 3;

    logic [NSYNC-1:0] s_cur;
    logic [NSYNC-1:0] s_prev;
    mv_evt_t          evt;
    logic             run_en;
    logic             restart;
    logic             advance;
    logic             tick;
    logic             q_r;
    logic             tap_r;

    // Either enable polarity starts free-running mode
    always_comb run_en = run_hi | ~run_lo_n;

    mvgen_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({rearm, trig_dn, trig_up}),
        .cur  (s_cur),
        .prev (s_prev)
    );

    mvgen_trigdec dec_i (
        .up_cur (s_cur[0]),
        .up_prev(s_prev[0]),
        .dn_cur (s_cur[1]),
        .dn_prev(s_prev[1]),
        .rt_cur (s_cur[2]),
        .rt_prev(s_prev[2]),
        .evt    (evt)
    );

    mvgen_timebase #(.CNT_W(CNT_W)) tb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .advance(advance),
        .len_in (period_len),
        .tick   (tick)
    );

    mvgen_ctrl ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .ext_clr(force_clr),
        .evt    (evt),
        .tick   (tick),
        .restart(restart),
        .advance(advance),
        .q_r    (q_r),
        .tap_r  (tap_r)
    );

    // Blank outputs in the same cycle as a forced clear; complement from one source
    always_comb begin
        pulse_out   = q_r & ~force_clr;
        pulse_out_n = ~pulse_out;
        osc_tap     = tap_r & ~force_clr;
    end

endmodule

// File: tb/mvgen_top_tb.sv
`timescale 1ns/1ps
// Bench for mvgen_top: a vector table of one-shot cases, then directed tests.
module mvgen_top_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_hi = 1'b0;
    logic             run_lo_n = 1'b1;
    logic             trig_up = 1'b0;
    logic             trig_dn = 1'b0;
    logic             rearm = 1'b0;
    logic             force_clr = 1'b0;
    logic [CNT_W-1:0] period_len = 16'd1;
    logic             pulse_out;
    logic             pulse_out_n;
    logic             osc_tap;

    int n_total = 0;
    int n_fail  = 0;
    int comp_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mvgen_top #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_hi     (run_hi),
        .run_lo_n   (run_lo_n),
        .trig_up    (trig_up),
        .trig_dn    (trig_dn),
        .rearm      (rearm),
        .force_clr  (force_clr),
        .period_len (period_len),
        .pulse_out  (pulse_out),
        .pulse_out_n(pulse_out_n),
        .osc_tap    (osc_tap)
    );

    typedef struct packed {
        logic        use_dn;
        logic [15:0] plen;
        logic [15:0] wexp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 16'd5,  16'd5},
        '{1'b0, 16'd1,  16'd1},
        '{1'b0, 16'd0,  16'd1},
        '{1'b1, 16'd3,  16'd3},
        '{1'b0, 16'd12, 16'd12},
        '{1'b1, 16'd0,  16'd1},
        '{1'b1, 16'd9,  16'd9},
        '{1'b0, 16'd2,  16'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R10 monitor: complement relation on every sampled cycle
    always @(negedge clk) begin
        if (rst_n && (pulse_out_n !== ~pulse_out)) comp_err++;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int w;
        int errs;
        int lows;
        int L;
        // R9: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(pulse_out == 1'b0, "R9 out", int'(pulse_out), 0);
        chk(pulse_out_n == 1'b1, "R9 out_n", int'(pulse_out_n), 1);
        chk(osc_tap == 1'b0, "R9 tap", int'(osc_tap), 0);
        rst_n = 1'b1;
        idle(5);

        // R4 R5: one-shot vector table
        foreach (VECS[k]) begin
            period_len = VECS[k].plen;
            if (VECS[k].use_dn) begin
                trig_dn = 1'b1; idle(4);
                trig_up = 1'b1; idle(4);
                trig_dn = 1'b0;
            end else begin
                trig_up = 1'b1;
            end
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk(pulse_out == 1'b0, VECS[k].use_dn ? "R5 early" : "R4 early", int'(pulse_out), 0);
            @(negedge clk);
            chk(pulse_out == 1'b1, VECS[k].use_dn ? "R5 start" : "R4 start", int'(pulse_out), 1);
            period_len = 16'd7;
            w = 1;
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                if (pulse_out) w++;
                else break;
            end
            chk(w == int'(VECS[k].wexp), VECS[k].use_dn ? "R5 width" : "R4 width", w, int'(VECS[k].wexp));
            trig_up = 1'b0;
            idle(5);
        end

        // R1 R2: free-running via active-high enable, L=3
        L = 3;
        period_len = 16'd3;
        run_hi = 1'b1;
        errs = 0;
        for (int i = 0; i < 8 * L; i++) begin
            @(negedge clk);
            if (i == 0) chk(pulse_out && osc_tap, "R1 start high", int'(pulse_out), 1);
            if (osc_tap !== (((i / L) % 2) == 0)) errs++;
            if (pulse_out !== (((i / (2 * L)) % 2) == 0)) errs++;
        end
        chk(errs == 0, "R2 waveform L3", errs, 0);

        // R3: gating off
        run_hi = 1'b0;
        @(negedge clk);
        chk(!pulse_out && !osc_tap, "R3 off", int'(pulse_out) + int'(osc_tap), 0);
        errs = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (pulse_out || osc_tap) errs++;
        end
        chk(errs == 0, "R3 stays off", errs, 0);

        // R1 R2: active-low enable, L=2
        L = 2;
        period_len = 16'd2;
        run_lo_n = 1'b0;
        errs = 0;
        for (int i = 0; i < 8 * L; i++) begin
            @(negedge clk);
            if (osc_tap !== (((i / L) % 2) == 0)) errs++;
            if (pulse_out !== (((i / (2 * L)) % 2) == 0)) errs++;
        end
        chk(errs == 0, "R1 R2 low enable", errs, 0);
        run_lo_n = 1'b1;
        idle(5);

        // R6: second trigger during active pulse is ignored
        period_len = 16'd20;
        trig_up = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        w = 1;
        for (int c = 0; c < 200; c++) begin
            if (c == 4) trig_up = 1'b0;
            if (c == 8) trig_up = 1'b1;
            @(negedge clk);
            if (pulse_out) w++;
            else break;
        end
        chk(w == 20, "R6 ignored retrigger", w, 20);
        trig_up = 1'b0;
        idle(6);

        // R7: re-arm start, hold and release
        period_len = 16'd4;
        rearm = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pulse_out == 1'b1, "R7 start", int'(pulse_out), 1);
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!pulse_out) lows++;
        end
        chk(lows == 0, "R7 held", lows, 0);
        rearm = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(pulse_out == 1'b1, "R7 before end", int'(pulse_out), 1);
        @(negedge clk);
        chk(pulse_out == 1'b0, "R7 end", int'(pulse_out), 0);
        idle(5);

        // R8: forced clear cuts a pulse and blocks triggers
        period_len = 16'd30;
        trig_up = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pulse_out == 1'b1, "R8 pre pulse", int'(pulse_out), 1);
        idle(3);
        force_clr = 1'b1;
        #1;
        chk(!pulse_out && pulse_out_n, "R8 immediate", int'(pulse_out), 0);
        @(negedge clk);
        trig_up = 1'b0;
        idle(4);
        trig_up = 1'b1;
        w = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pulse_out) w++;
        end
        chk(w == 0, "R8 blocked while held", w, 0);
        force_clr = 1'b0;
        w = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pulse_out) w++;
        end
        chk(w == 0, "R8 no pulse after release", w, 0);
        trig_up = 1'b0;
        idle(5);

        // R8: forced clear blanks the tap in free-running mode
        period_len = 16'd4;
        run_hi = 1'b1;
        @(negedge clk);
        chk(osc_tap == 1'b1, "R8 tap before", int'(osc_tap), 1);
        force_clr = 1'b1;
        #1;
        chk(!osc_tap && !pulse_out, "R8 tap blanked", int'(osc_tap), 0);
        @(negedge clk);
        run_hi = 1'b0;
        force_clr = 1'b0;
        idle(3);

        // R10: complement across the whole run
        chk(comp_err == 0, "R10 complement", comp_err, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule